// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the execute stage of a 32-bit load-store core and a data memory that is one word wide and addressed by word. From a base register value and a 16-bit displacement it forms the byte address and splits it into a word address and a byte offset. For stores it moves the register data into the byte lanes that the access covers and drives matching byte enables and a write strobe. For loads it drives a read strobe in the same cycle. In the following cycle, when the memory word comes back, it picks out the addressed byte, halfword or word and extends it to 32 bits.

Lanes follow big-endian order. Byte offset 0 is the most significant byte of the memory word, so a halfword at address a takes the byte at a as its upper half. Byte loads come in a signed form and an unsigned form. Halfword loads are always sign-extended. A halfword at an odd address, or a word at an address that is not a multiple of four, is flagged as misaligned and never reaches memory.

Top module: `lsa_lane_aligner`

## Requirements
- R1: The byte address is base_i plus disp_i sign-extended to 32 bits, with a modulo-2^32 wrap. mem_addr_o carries address bits 31..2 and the low two bits form the byte offset. A zero base gives absolute addressing.
- R2: Bit j of mem_be_o enables data bits 8j+7..8j, so byte offset 0 maps to bit 3 and offset 3 maps to bit 0. An aligned access enables exactly one bit for a byte, 4'b1100 or 4'b0011 for a halfword, and 4'b1111 for a word.
- R3: A byte store (acc_i = 5) drives mem_we_o and places st_data_i[7:0] in the addressed lane. All other lanes of mem_wdata_o are zero.
- R4: A halfword store (acc_i = 6) places st_data_i[15:0] in the addressed halfword and leaves the other halfword zero.
- R5: A word store (acc_i = 7) at offset 0 writes st_data_i unchanged.
- R6: A halfword access (acc_i = 3 or 6) at an odd offset, or a word access (acc_i = 4 or 7) at a nonzero offset, raises misalign_o. It then drives mem_be_o, mem_we_o and mem_re_o low and mem_wdata_o to zero. Byte accesses are never misaligned.
- R7: An aligned load (acc_i = 1 to 4) raises mem_re_o in the same cycle and never together with mem_we_o. ld_valid_o is high in the cycle after a cycle with mem_re_o high, and low in every other cycle.
- R8: A signed byte load (acc_i = 1) returns the addressed byte of mem_rdata_i with its bit 7 copied into bits 31..8.
- R9: An unsigned byte load (acc_i = 2) returns the addressed byte with bits 31..8 zero.
- R10: A halfword load (acc_i = 3) returns the byte at offset a in bits 15..8 and the byte at a+1 in bits 7..0, sign-extended from bit 15.
- R11: A word load (acc_i = 4) returns mem_rdata_i unchanged.
- R12: Code 0 is idle: no strobe, no enables, no misalign flag and zero write data. While rst_ni is low and whenever ld_valid_o is low, ld_valid_o and ld_data_o are zero, and asserting reset cancels a pending load result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 3 | Access code: 0 idle, 1 signed byte load, 2 unsigned byte load, 3 halfword load, 4 word load, 5 byte store, 6 halfword store, 7 word store |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| st_data_i | input | 32 | Store data from the register file |
| mem_addr_o | output | 30 | Word address to memory |
| mem_be_o | output | 4 | Byte enables, bit 3 = most significant lane |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_wdata_o | output | 32 | Lane-placed write data |
| misalign_o | output | 1 | Misaligned access flag |
| mem_rdata_i | input | 32 | Memory word returned the cycle after mem_re_o |
| ld_data_o | output | 32 | Extended load result |
| ld_valid_o | output | 1 | Load result valid |

## Verification
The assertions assume that memory returns the read word in the cycle after mem_re_o and that acc_i holds one of the eight codes for the whole cycle. They make no assumption about the value of mem_rdata_i, only about which bits of ld_data_o must be zero or sign copies. The stimulus changes acc_i, the operands and mem_rdata_i only on the falling edge. It presents each load's return word exactly one cycle after the request, and it sets acc_i to idle during that return cycle unless a back-to-back load is being exercised on purpose.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LB   = 3'd1,
    ACC_LBU  = 3'd2,
    ACC_LH   = 3'd3,
    ACC_LW   = 3'd4,
    ACC_SB   = 3'd5,
    ACC_SH   = 3'd6,
    ACC_SW   = 3'd7
  } acc_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  is_load;
    logic  is_store;
    logic  sign;
    size_e size;
  } acc_dec_t;

  function automatic acc_dec_t decode_acc(input acc_e a);
    acc_dec_t d;
    d = '{is_load: 1'b0, is_store: 1'b0, sign: 1'b0, size: SZ_WORD};
    case (a)
      ACC_LB:  d = '{is_load: 1'b1, is_store: 1'b0, sign: 1'b1, size: SZ_BYTE};
      ACC_LBU: d = '{is_load: 1'b1, is_store: 1'b0, sign: 1'b0, size: SZ_BYTE};
      ACC_LH:  d = '{is_load: 1'b1, is_store: 1'b0, sign: 1'b1, size: SZ_HALF};
      ACC_LW:  d = '{is_load: 1'b1, is_store: 1'b0, sign: 1'b0, size: SZ_WORD};
      ACC_SB:  d = '{is_load: 1'b0, is_store: 1'b1, sign: 1'b0, size: SZ_BYTE};
      ACC_SH:  d = '{is_load: 1'b0, is_store: 1'b1, sign: 1'b0, size: SZ_HALF};
      ACC_SW:  d = '{is_load: 1'b0, is_store: 1'b1, sign: 1'b0, size: SZ_WORD};
      default: d = '{is_load: 1'b0, is_store: 1'b0, sign: 1'b0, size: SZ_WORD};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsa_agen.sv
module lsa_agen #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [DATA_W-1:0] ea_o
);

  localparam int SEXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] disp_ext;

  assign disp_ext = {{SEXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o     = base_i + disp_ext;

endmodule

// File: rtl/lsa_lane_ctrl.sv
module lsa_lane_ctrl
  import lsa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic             active_i,
  input  size_e            size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] be_o,
  output logic             misalign_o
);

  int span;

  always_comb begin
    case (size_i)
      SZ_BYTE: span = 1;
      SZ_HALF: span = 2;
      default: span = LANES;
    endcase
  end

  always_comb begin
    case (size_i)
      SZ_HALF: misalign_o = active_i & off_i[0];
      SZ_WORD: misalign_o = active_i & (|off_i);
      default: misalign_o = 1'b0;
    endcase
  end

  // lane k (offset k) is enable bit LANES-1-k: big-endian order
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      be_o[LANES-1-k] = active_i & ~misalign_o &
                        (k >= int'(off_i)) & (k < int'(off_i) + span);
    end
  end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  size_e             size_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [DATA_W-1:0] wdata_o
);

  localparam int HALVES = LANES / 2;

  logic [DATA_W-1:0] repl;

  // replicate the source so every candidate lane already holds it
  always_comb begin
    case (size_i)
      SZ_BYTE: repl = {LANES{st_data_i[7:0]}};
      SZ_HALF: repl = {HALVES{st_data_i[15:0]}};
      default: repl = st_data_i;
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign wdata_o[8*j +: 8] = lane_en_i[j] ? repl[8*j +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  size_e             size_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int HALVES = LANES / 2;

  logic [7:0]  byte_lane [LANES];
  logic [15:0] half_lane [HALVES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign byte_lane[k] = rdata_i[DATA_W-1-8*k -: 8];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_lane[h] = rdata_i[DATA_W-1-16*h -: 16];
  end

  assign sel_b = byte_lane[off_i];
  assign sel_h = half_lane[off_i[OFF_W-1:1]];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){sign_i & sel_b[7]}}, sel_b};
      SZ_HALF: data_o = {{(DATA_W-16){sel_h[15]}}, sel_h};
      default: data_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WADR_W = DATA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        acc_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [WADR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              misalign_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_valid_o
);

  acc_dec_t          dec;
  logic [DATA_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  logic              active;
  logic              mis;
  logic [LANES-1:0]  be;
  logic [LANES-1:0]  st_lanes;
  logic [DATA_W-1:0] ext_data;

  logic              ld_pend_q;
  logic [OFF_W-1:0]  ld_off_q;
  size_e             ld_size_q;
  logic              ld_sign_q;

  assign dec    = decode_acc(acc_e'(acc_i));
  assign active = dec.is_load | dec.is_store;

  lsa_agen #(
    .DATA_W(DATA_W),
    .DISP_W(DISP_W)
  ) i_agen (
    .base_i(base_i),
    .disp_i(disp_i),
    .ea_o  (ea)
  );

  assign off        = ea[OFF_W-1:0];
  assign mem_addr_o = ea[DATA_W-1:OFF_W];

  lsa_lane_ctrl #(
    .LANES(LANES),
    .OFF_W(OFF_W)
  ) i_lane_ctrl (
    .active_i  (active),
    .size_i    (dec.size),
    .off_i     (off),
    .be_o      (be),
    .misalign_o(mis)
  );

  assign mem_be_o   = be;
  assign misalign_o = mis;
  assign mem_we_o   = dec.is_store & ~mis;
  assign mem_re_o   = dec.is_load & ~mis;
  assign st_lanes   = be & {LANES{dec.is_store}};

  lsa_store_lane #(
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) i_store_lane (
    .size_i   (dec.size),
    .st_data_i(st_data_i),
    .lane_en_i(st_lanes),
    .wdata_o  (mem_wdata_o)
  );

  // load attributes wait one cycle for the memory word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_off_q  <= '0;
      ld_size_q <= SZ_WORD;
      ld_sign_q <= 1'b0;
    end else begin
      ld_pend_q <= mem_re_o;
      if (mem_re_o) begin
        ld_off_q  <= off;
        ld_size_q <= dec.size;
        ld_sign_q <= dec.sign;
      end
    end
  end

  lsa_load_ext #(
    .DATA_W(DATA_W),
    .LANES (LANES),
    .OFF_W (OFF_W)
  ) i_load_ext (
    .rdata_i(mem_rdata_i),
    .off_i  (ld_off_q),
    .size_i (ld_size_q),
    .sign_i (ld_sign_q),
    .data_o (ext_data)
  );

  assign ld_valid_o = ld_pend_q;
  assign ld_data_o  = ld_pend_q ? ext_data : '0;

endmodule

// File: rtl/lsa_lane_aligner_chk.sv
module lsa_lane_aligner_chk
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        acc_i,
  input logic [LANES-1:0]  mem_be_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              misalign_o,
  input logic [DATA_W-1:0] ld_data_o,
  input logic              ld_valid_o
);

  assert_byte_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_o || mem_re_o) &&
     (acc_i == ACC_LB || acc_i == ACC_LBU || acc_i == ACC_SB)) |-> ($countones(mem_be_o) == 1));

  assert_word_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_o || mem_re_o) && (acc_i == ACC_LW || acc_i == ACC_SW)) |-> (&mem_be_o));

  assert_misalign_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0 && !mem_we_o && !mem_re_o));

  assert_byte_never_mis_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_LB || acc_i == ACC_LBU || acc_i == ACC_SB) |-> !misalign_o);

  assert_rw_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ld_valid_o);

  assert_no_stray_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_re_o |=> !ld_valid_o);

  assert_lb_sext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && acc_i == ACC_LB) |=>
      (ld_data_o[DATA_W-1:8] == {(DATA_W-8){ld_data_o[7]}}));

  assert_lbu_zext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && acc_i == ACC_LBU) |=> (ld_data_o[DATA_W-1:8] == '0));

  assert_lh_sext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && acc_i == ACC_LH) |=>
      (ld_data_o[DATA_W-1:16] == {(DATA_W-16){ld_data_o[15]}}));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_NONE) |-> (mem_be_o == '0 && !mem_we_o && !mem_re_o && !misalign_o));

  assert_result_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_o |-> (ld_data_o == '0));

endmodule

bind lsa_lane_aligner lsa_lane_aligner_chk #(
  .DATA_W(DATA_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_i     (acc_i),
  .mem_be_o  (mem_be_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .misalign_o(misalign_o),
  .ld_data_o (ld_data_o),
  .ld_valid_o(ld_valid_o)
);

// File: tb/test_lsa_lane_aligner.sv
module test_lsa_lane_aligner;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  acc_i = 3'd0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] st_data_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic        mem_we_o;
  logic        mem_re_o;
  logic [31:0] mem_wdata_o;
  logic        misalign_o;
  logic [31:0] ld_data_o;
  logic        ld_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lsa_lane_aligner i_lsa_lane_aligner (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .acc_i      (acc_i),
    .base_i     (base_i),
    .disp_i     (disp_i),
    .st_data_i  (st_data_i),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_wdata_o(mem_wdata_o),
    .misalign_o (misalign_o),
    .mem_rdata_i(mem_rdata_i),
    .ld_data_o  (ld_data_o),
    .ld_valid_o (ld_valid_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  acc;
    logic [31:0] base;
    logic [15:0] disp;
    logic [31:0] st;
    logic [31:0] rdata;
    logic [31:0] ea;
    logic [3:0]  be;
    logic        we;
    logic        re;
    logic        mis;
    logic [31:0] wdata;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  3'd7, 32'h0000_1000, 16'h0010, 32'hDEAD_BEEF, 32'h0, 32'h0000_1010, 4'b1111, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0}, // R5
    '{4'd3,  3'd5, 32'h0000_1000, 16'h0001, 32'h1234_56AB, 32'h0, 32'h0000_1001, 4'b0100, 1'b1, 1'b0, 1'b0, 32'h00AB_0000, 32'h0}, // R3
    '{4'd3,  3'd5, 32'h0000_2003, 16'h0000, 32'h0000_00CD, 32'h0, 32'h0000_2003, 4'b0001, 1'b1, 1'b0, 1'b0, 32'h0000_00CD, 32'h0}, // R3
    '{4'd4,  3'd6, 32'h0000_2000, 16'h0002, 32'hFFFF_8A5C, 32'h0, 32'h0000_2002, 4'b0011, 1'b1, 1'b0, 1'b0, 32'h0000_8A5C, 32'h0}, // R4
    '{4'd4,  3'd6, 32'h0000_2000, 16'h0000, 32'h0000_1234, 32'h0, 32'h0000_2000, 4'b1100, 1'b1, 1'b0, 1'b0, 32'h1234_0000, 32'h0}, // R4
    '{4'd6,  3'd6, 32'h0000_2001, 16'h0000, 32'h0000_BEEF, 32'h0, 32'h0000_2001, 4'b0000, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0},         // R6
    '{4'd6,  3'd7, 32'h0000_3002, 16'h0000, 32'h0102_0304, 32'h0, 32'h0000_3002, 4'b0000, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0},         // R6
    '{4'd8,  3'd1, 32'h0000_4000, 16'hFFFE, 32'h0, 32'h1122_A344, 32'h0000_3FFE, 4'b0010, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFA3}, // R8, R1 negative disp
    '{4'd9,  3'd2, 32'h0000_4000, 16'hFFFE, 32'h0, 32'h1122_A344, 32'h0000_3FFE, 4'b0010, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_00A3}, // R9
    '{4'd8,  3'd1, 32'h0000_0000, 16'h0100, 32'h0, 32'h7F00_FF00, 32'h0000_0100, 4'b1000, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_007F}, // R8, R1 absolute
    '{4'd10, 3'd3, 32'h0000_5000, 16'h0000, 32'h0, 32'h8001_2233, 32'h0000_5000, 4'b1100, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFF_8001}, // R10
    '{4'd10, 3'd3, 32'h0000_5000, 16'h0002, 32'h0, 32'h8001_2233, 32'h0000_5002, 4'b0011, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_2233}, // R10
    '{4'd11, 3'd4, 32'h0000_6000, 16'h7FFC, 32'h0, 32'hCAFE_F00D, 32'h0000_DFFC, 4'b1111, 1'b0, 1'b1, 1'b0, 32'h0, 32'hCAFE_F00D}, // R11
    '{4'd6,  3'd3, 32'h0000_5003, 16'h0000, 32'h0, 32'hFFFF_FFFF, 32'h0000_5003, 4'b0000, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0},         // R6
    '{4'd6,  3'd4, 32'h0000_6001, 16'h0000, 32'h0, 32'hFFFF_FFFF, 32'h0000_6001, 4'b0000, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0},         // R6
    '{4'd12, 3'd0, 32'h0000_1234, 16'h0000, 32'hFFFF_FFFF, 32'h0, 32'h0000_1234, 4'b0000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0},         // R12
    '{4'd1,  3'd5, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0055, 32'h0, 32'h0000_0000, 4'b1000, 1'b1, 1'b0, 1'b0, 32'h5500_0000, 32'h0}, // R1 wrap, R3
    '{4'd9,  3'd2, 32'h0000_7000, 16'h0003, 32'h0, 32'h0000_00F0, 32'h0000_7003, 4'b0001, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_00F0}, // R9
    '{4'd8,  3'd1, 32'h0000_7001, 16'h0000, 32'h0, 32'h0080_0000, 32'h0000_7001, 4'b0100, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFF_FF80}  // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 ld_valid in reset", {31'b0, ld_valid_o}, 32'h0);
    chk("R12 ld_data in reset", ld_data_o, 32'h0);
    chk("R12 be idle in reset", {28'b0, mem_be_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_i = VEC[i].acc;
      base_i = VEC[i].base;
      disp_i = VEC[i].disp;
      st_data_i = VEC[i].st;
      mem_rdata_i = '0;
      #2;
      chk($sformatf("R1 addr vec%0d", i), {2'b0, mem_addr_o}, {2'b0, VEC[i].ea[31:2]});
      chk($sformatf("R2 be vec%0d", i), {28'b0, mem_be_o}, {28'b0, VEC[i].be});
      chk($sformatf("R%0d we vec%0d", VEC[i].req, i), {31'b0, mem_we_o}, {31'b0, VEC[i].we});
      chk($sformatf("R7 re vec%0d", i), {31'b0, mem_re_o}, {31'b0, VEC[i].re});
      chk($sformatf("R6 misalign vec%0d", i), {31'b0, misalign_o}, {31'b0, VEC[i].mis});
      chk($sformatf("R%0d wdata vec%0d", VEC[i].req, i), mem_wdata_o, VEC[i].wdata);
      @(negedge clk);
      acc_i = 3'd0;
      mem_rdata_i = VEC[i].rdata;
      #2;
      chk($sformatf("R7 ld_valid vec%0d", i), {31'b0, ld_valid_o}, {31'b0, VEC[i].re});
      if (VEC[i].re)
        chk($sformatf("R%0d ld_data vec%0d", VEC[i].req, i), ld_data_o, VEC[i].ld);
    end

    // back-to-back loads: R9 then R10
    @(negedge clk);
    acc_i = 3'd2; base_i = 32'h0000_7002; disp_i = 16'h0000;
    @(negedge clk);
    acc_i = 3'd3; base_i = 32'h0000_5002;
    mem_rdata_i = 32'h0000_C300;
    #2;
    chk("R9 back-to-back ld_data", ld_data_o, 32'h0000_00C3);
    chk("R7 back-to-back re", {31'b0, mem_re_o}, 32'h1);
    @(negedge clk);
    acc_i = 3'd0;
    mem_rdata_i = 32'h1111_FFFE;
    #2;
    chk("R10 back-to-back ld_data", ld_data_o, 32'hFFFF_FFFE);
    chk("R7 back-to-back valid", {31'b0, ld_valid_o}, 32'h1);

    // reset while a result is pending: R12
    @(negedge clk);
    acc_i = 3'd4; base_i = 32'h0000_0040; disp_i = 16'h0000;
    @(negedge clk);
    acc_i = 3'd0;
    mem_rdata_i = 32'h0000_0001;
    #2;
    chk("R7 pending valid", {31'b0, ld_valid_o}, 32'h1);
    rst_ni = 1'b0;
    #2;
    chk("R12 reset cancels valid", {31'b0, ld_valid_o}, 32'h0);
    chk("R12 reset clears data", ld_data_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #2;
    chk("R12 no valid after reset", {31'b0, ld_valid_o}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule